// File: doc/BRIEF.md
# Masked Ternary-Compare CAM with Priority Resolution

This block is a small content-addressable store. Every entry holds a search field, a data field and a two-bit type code that marks it as Empty, Valid, Skip or RAM-only. On a compare strobe, a search word is checked against the search field of every entry of one selected type. Bit positions flagged in a compare mask are ignored. All hitting entries go to a priority resolver. It registers the lowest hitting index, a hit flag and a flag that reports more than one hit.

A plain compare looks only at entries of type Valid. A forced compare names the type to search, so the host can also look for a pattern among Skip, RAM-only or Empty entries, for example when purging. Writes can protect chosen bits of the search field through a write mask. A read returns the entry's fields and latches its type code into a status register. A combinational free-slot output always points at the lowest Empty entry, and a full flag is raised when no entry is Empty.

Top module: `masked_cam`

## Requirements
- R1: After reset every entry is Empty, with zero search and data fields. `match_flag`, `multi_flag`, `match_addr` and `rd_status` read 0, `free_addr` reads 0 and `full_flag` reads 0.
- R2: The type code is 2'b00 Empty, 2'b01 Valid, 2'b10 Skip and 2'b11 RAM-only. A write with `wr_en` high stores `wr_type`, `wr_data` and the search field at `wr_addr` on the next rising edge.
- R3: During a write, each search-field bit whose `wr_mask` bit is 1 keeps its old value, and each bit whose `wr_mask` bit is 0 takes `wr_key`. The data field is always written in full.
- R4: A compare with `cmp_auto` high and `cmp_force` low searches only entries of type Valid.
- R5: A compare with `cmp_force` high searches only entries whose type equals `cmp_type`. When `cmp_force` and `cmp_auto` are both high, the forced type wins.
- R6: A `cmp_mask` bit at 1 makes that bit position a don't-care for every entry. An entry hits when all unmasked bits of its search field equal `cmp_key`.
- R7: `match_flag` is 1 when at least one entry hits. `match_addr` is then the lowest-numbered hitting entry. With no hit, `match_addr` is 0.
- R8: `multi_flag` is 1 exactly when two or more entries hit.
- R9: The compare results are updated on the rising edge where a strobe is sampled, and are visible one clock after the strobe. They hold their values until the next strobe, whatever the other inputs do.
- R10: A read with `rd_en` high returns the entry's search and data fields on `rd_key` and `rd_data`, and copies its type code into `rd_status`, one clock later. These values hold until the next read.
- R11: `free_addr` gives the lowest-numbered Empty entry. `full_flag` is 1 when no entry is Empty, and `free_addr` is then 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Entry to write |
| wr_key | input | KEY_W | New search field |
| wr_data | input | DATA_W | New data field |
| wr_type | input | 2 | New type code |
| wr_mask | input | KEY_W | Search-field bits to protect (1 = keep) |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | AW | Entry to read |
| rd_key | output | KEY_W | Search field of the last read entry |
| rd_data | output | DATA_W | Data field of the last read entry |
| rd_status | output | 2 | Type code of the last read entry |
| cmp_auto | input | 1 | Compare against Valid entries |
| cmp_force | input | 1 | Compare against entries of `cmp_type` |
| cmp_type | input | 2 | Type searched by a forced compare |
| cmp_key | input | KEY_W | Search word |
| cmp_mask | input | KEY_W | Compare don't-care bits (1 = ignore) |
| match_flag | output | 1 | At least one hit in the last compare |
| multi_flag | output | 1 | Two or more hits in the last compare |
| match_addr | output | AW | Lowest hitting entry of the last compare |
| free_addr | output | AW | Lowest Empty entry |
| full_flag | output | 1 | No entry is Empty |

## Verification
Every cycle, the assertions check that a multiple hit implies a hit, that the compare outputs do not change without a strobe, and that the hit flag agrees with the hit vector sampled at the strobe. They also check that the reported address is a hitting entry with no lower hitting entry, and that the free-slot output points at an Empty entry unless the store is full. Only the bench scenarios can show that the right entries hit. This covers type selection, auto versus forced priority, mask don't-cares, write masking of stored bits, and read-back of fields and status. The bench shows this by sweeping every type against every stored key and several masks, and comparing the results with a model kept in the bench.

// File: rtl/cam_pkg.sv
package cam_pkg;
  typedef enum logic [1:0] {
    VT_EMPTY = 2'b00,
    VT_VALID = 2'b01,
    VT_SKIP  = 2'b10,
    VT_RAM   = 2'b11
  } vtype_e;
endpackage

// File: rtl/cam_hit_vec.sv
module cam_hit_vec #(
  parameter int N     = 8,
  parameter int KEY_W = 8
) (
  input  logic [N*KEY_W-1:0] keys_flat,
  input  logic [N*2-1:0]     types_flat,
  input  logic [KEY_W-1:0]   cmp_key,
  input  logic [KEY_W-1:0]   cmp_mask,
  input  logic [1:0]         sel_type,
  output logic [N-1:0]       hit_vec,
  output logic [N-1:0]       empty_vec
);
  import cam_pkg::*;

  // unmasked bits must all agree
  function automatic logic key_hits(input logic [KEY_W-1:0] stored,
                                    input logic [KEY_W-1:0] key,
                                    input logic [KEY_W-1:0] dont_care);
    return ((stored ^ key) & ~dont_care) == '0;
  endfunction

  for (genvar g = 0; g < N; g++) begin : g_line
    logic [KEY_W-1:0] stored;
    logic [1:0]       typ;
    assign stored       = keys_flat[g*KEY_W +: KEY_W];
    assign typ          = types_flat[g*2 +: 2];
    assign hit_vec[g]   = (typ == sel_type) && key_hits(stored, cmp_key, cmp_mask);
    assign empty_vec[g] = (typ == VT_EMPTY);
  end
endmodule

// File: rtl/cam_prio_enc.sv
module cam_prio_enc #(
  parameter int N  = 8,
  parameter int AW = 3
) (
  input  logic [N-1:0]  req,
  output logic [AW-1:0] idx,
  output logic          any,
  output logic          multi
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = AW'(i);
    end
  end

  always_comb begin
    any   = 1'b0;
    multi = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i]) begin
        if (any) multi = 1'b1;
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/masked_cam.sv
module masked_cam #(
  parameter int ENTRIES = 8,
  parameter int KEY_W   = 8,
  parameter int DATA_W  = 8,
  localparam int AW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [KEY_W-1:0]  wr_key,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        wr_type,
  input  logic [KEY_W-1:0]  wr_mask,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [KEY_W-1:0]  rd_key,
  output logic [DATA_W-1:0] rd_data,
  output logic [1:0]        rd_status,
  input  logic              cmp_auto,
  input  logic              cmp_force,
  input  logic [1:0]        cmp_type,
  input  logic [KEY_W-1:0]  cmp_key,
  input  logic [KEY_W-1:0]  cmp_mask,
  output logic              match_flag,
  output logic              multi_flag,
  output logic [AW-1:0]     match_addr,
  output logic [AW-1:0]     free_addr,
  output logic              full_flag
);
  import cam_pkg::*;

  // protected bits keep old content
  function automatic logic [KEY_W-1:0] merge_key(input logic [KEY_W-1:0] old_v,
                                                 input logic [KEY_W-1:0] new_v,
                                                 input logic [KEY_W-1:0] keep);
    return (old_v & keep) | (new_v & ~keep);
  endfunction

  logic [KEY_W-1:0]  key_q  [ENTRIES];
  logic [DATA_W-1:0] data_q [ENTRIES];
  logic [1:0]        type_q [ENTRIES];

  logic [ENTRIES*KEY_W-1:0] keys_flat;
  logic [ENTRIES*2-1:0]     types_flat;
  logic [ENTRIES-1:0]       hit_vec;
  logic [ENTRIES-1:0]       empty_vec;
  logic [AW-1:0]            hit_idx;
  logic                     hit_any;
  logic                     hit_multi;
  logic                     free_any;
  logic                     free_multi;
  logic                     cmp_strobe;
  logic [1:0]               sel_type;
  logic                     wr_ok;
  logic                     rd_ok;

  assign cmp_strobe = cmp_auto | cmp_force;
  assign sel_type   = cmp_force ? cmp_type : VT_VALID;
  assign wr_ok      = wr_en && (int'(wr_addr) < ENTRIES);
  assign rd_ok      = rd_en && (int'(rd_addr) < ENTRIES);

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      keys_flat[i*KEY_W +: KEY_W] = key_q[i];
      types_flat[i*2 +: 2]        = type_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        key_q[i]  <= '0;
        data_q[i] <= '0;
        type_q[i] <= VT_EMPTY;
      end
    end else if (wr_ok) begin
      key_q[wr_addr]  <= merge_key(key_q[wr_addr], wr_key, wr_mask);
      data_q[wr_addr] <= wr_data;
      type_q[wr_addr] <= wr_type;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_key    <= '0;
      rd_data   <= '0;
      rd_status <= VT_EMPTY;
    end else if (rd_ok) begin
      rd_key    <= key_q[rd_addr];
      rd_data   <= data_q[rd_addr];
      rd_status <= type_q[rd_addr];
    end
  end

  cam_hit_vec #(.N(ENTRIES), .KEY_W(KEY_W)) u_hits (
    .keys_flat  (keys_flat),
    .types_flat (types_flat),
    .cmp_key    (cmp_key),
    .cmp_mask   (cmp_mask),
    .sel_type   (sel_type),
    .hit_vec    (hit_vec),
    .empty_vec  (empty_vec)
  );

  cam_prio_enc #(.N(ENTRIES), .AW(AW)) u_hit_enc (
    .req   (hit_vec),
    .idx   (hit_idx),
    .any   (hit_any),
    .multi (hit_multi)
  );

  cam_prio_enc #(.N(ENTRIES), .AW(AW)) u_free_enc (
    .req   (empty_vec),
    .idx   (free_addr),
    .any   (free_any),
    .multi (free_multi)
  );

  assign full_flag = ~free_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_flag <= 1'b0;
      multi_flag <= 1'b0;
      match_addr <= '0;
    end else if (cmp_strobe) begin
      match_flag <= hit_any;
      multi_flag <= hit_multi;
      match_addr <= hit_idx;
    end
  end
endmodule

// File: rtl/cam_chk.sv
module cam_chk #(
  parameter int N  = 8,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmp_strobe,
  input logic [N-1:0]  hit_vec,
  input logic [N-1:0]  empty_vec,
  input logic          match_flag,
  input logic          multi_flag,
  input logic [AW-1:0] match_addr,
  input logic [AW-1:0] free_addr,
  input logic          full_flag
);
  logic [N-1:0] hit_snap;
  logic [N-1:0] below_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_snap <= '0;
    else if (cmp_strobe) hit_snap <= hit_vec;
  end

  always_comb begin
    below_mask = '0;
    for (int i = 0; i < N; i++) below_mask[i] = (i < int'(match_addr));
  end

  a_r8_multi_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
    multi_flag |-> match_flag);

  a_r9_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_strobe |=> ($stable(match_flag) && $stable(multi_flag) && $stable(match_addr)));

  a_r7_flag_follows_hits: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_strobe |=> (match_flag == ($past(hit_vec) != '0)));

  a_r7_addr_is_hit: assert property (@(posedge clk) disable iff (!rst_n)
    match_flag |-> hit_snap[match_addr]);

  a_r7_addr_is_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    match_flag |-> ((hit_snap & below_mask) == '0));

  a_r11_free_is_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !full_flag |-> empty_vec[free_addr]);

  a_r11_full_no_empty: assert property (@(posedge clk) disable iff (!rst_n)
    full_flag |-> (empty_vec == '0));
endmodule

bind masked_cam cam_chk #(.N(ENTRIES), .AW(AW)) u_cam_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmp_strobe (cmp_strobe),
  .hit_vec    (hit_vec),
  .empty_vec  (empty_vec),
  .match_flag (match_flag),
  .multi_flag (multi_flag),
  .match_addr (match_addr),
  .free_addr  (free_addr),
  .full_flag  (full_flag)
);

// File: tb/tb_masked_cam.sv
module tb_masked_cam;
  localparam int N  = 8;
  localparam int KW = 8;
  localparam int DW = 8;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, cmp_auto = 1'b0, cmp_force = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [KW-1:0] wr_key = '0, wr_mask = '0, cmp_key = '0, cmp_mask = '0;
  logic [DW-1:0] wr_data = '0;
  logic [1:0]    wr_type = '0, cmp_type = '0;
  logic [KW-1:0] rd_key;
  logic [DW-1:0] rd_data;
  logic [1:0]    rd_status;
  logic          match_flag, multi_flag, full_flag;
  logic [AW-1:0] match_addr, free_addr;

  int checks = 0;
  int errors = 0;

  logic [KW-1:0] m_key  [N];
  logic [DW-1:0] m_data [N];
  logic [1:0]    m_type [N];

  always #10 clk = ~clk;

  masked_cam #(.ENTRIES(N), .KEY_W(KW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_key(wr_key), .wr_data(wr_data),
    .wr_type(wr_type), .wr_mask(wr_mask),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_key(rd_key), .rd_data(rd_data),
    .rd_status(rd_status),
    .cmp_auto(cmp_auto), .cmp_force(cmp_force), .cmp_type(cmp_type),
    .cmp_key(cmp_key), .cmp_mask(cmp_mask),
    .match_flag(match_flag), .multi_flag(multi_flag), .match_addr(match_addr),
    .free_addr(free_addr), .full_flag(full_flag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_wr(input int a, input logic [KW-1:0] k, input logic [DW-1:0] d,
                       input logic [1:0] t, input logic [KW-1:0] m);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_key = k; wr_data = d; wr_type = t; wr_mask = m;
    @(negedge clk);
    wr_en = 1'b0;
    // R3: bench restates the keep rule bit by bit
    for (int b = 0; b < KW; b++) if (!m[b]) m_key[a][b] = k[b];
    m_data[a] = d;
    m_type[a] = t;
  endtask

  task automatic do_rd(input int a);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = AW'(a);
    @(negedge clk);
    rd_en = 1'b0;
    chk(rd_key == m_key[a], "R10 key", int'(rd_key), int'(m_key[a]));
    chk(rd_data == m_data[a], "R10 data", int'(rd_data), int'(m_data[a]));
    chk(rd_status == m_type[a], "R10 status", int'(rd_status), int'(m_type[a]));
  endtask

  task automatic do_cmp(input logic f, input logic au, input logic [1:0] t,
                        input logic [KW-1:0] k, input logic [KW-1:0] m, input string req);
    logic [1:0] want_t;
    int hits;
    int first;
    @(negedge clk);
    cmp_force = f; cmp_auto = au; cmp_type = t; cmp_key = k; cmp_mask = m;
    @(negedge clk);
    cmp_force = 1'b0; cmp_auto = 1'b0;
    want_t = f ? t : 2'b01;
    hits = 0; first = 0;
    for (int i = N - 1; i >= 0; i--) begin
      if (m_type[i] == want_t && $countones((m_key[i] ^ k) & ~m) == 0) begin
        hits++;
        first = i;
      end
    end
    chk(match_flag == (hits > 0), {req, " R7 flag"}, int'(match_flag), int'(hits > 0));
    chk(multi_flag == (hits > 1), {req, " R8 multi"}, int'(multi_flag), int'(hits > 1));
    chk(int'(match_addr) == first, {req, " R7 addr"}, int'(match_addr), first);
  endtask

  task automatic chk_free(input string tag);
    int lo;
    lo = -1;
    for (int i = 0; i < N; i++) if (lo < 0 && m_type[i] == 2'b00) lo = i;
    chk(full_flag == (lo < 0), {tag, " R11 full"}, int'(full_flag), int'(lo < 0));
    chk(int'(free_addr) == (lo < 0 ? 0 : lo), {tag, " R11 free"}, int'(free_addr),
        (lo < 0 ? 0 : lo));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic mf, mu;
    logic [AW-1:0] ma;
    for (int i = 0; i < N; i++) begin m_key[i] = '0; m_data[i] = '0; m_type[i] = 2'b00; end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(match_flag == 1'b0 && multi_flag == 1'b0 && match_addr == '0, "R1 compare outs",
        int'({match_flag, multi_flag, match_addr}), 0);
    chk(rd_status == 2'b00 && rd_key == '0 && rd_data == '0, "R1 read outs",
        int'({rd_status, rd_key}), 0);
    chk(full_flag == 1'b0 && free_addr == '0, "R1 free", int'({full_flag, free_addr}), 0);
    rst_n = 1'b1;
    do_rd(5);
    chk_free("R1 after release");

    // R2: fill, types cycle Empty/Valid/Skip/RAM with repeated key families
    for (int i = 0; i < N; i++)
      do_wr(i, KW'((i % 3) * 8'h21 + 8'h40), DW'(8'hA0 + i), 2'((i * 3 + 1) % 4), '0);
    chk_free("R11 after fill");
    for (int i = 0; i < N; i++) do_rd(i);

    // R4/R5/R6: sweep every type, every stored key plus a miss, several masks
    for (int t = 0; t < 4; t++)
      for (int e = 0; e <= N; e++)
        for (int mi = 0; mi < 3; mi++)
          do_cmp(1'b1, 1'b0, 2'(t), (e == N) ? 8'h13 : m_key[e],
                 (mi == 0) ? 8'h00 : (mi == 1) ? 8'h0F : 8'hFF, "R5 forced");
    for (int e = 0; e <= N; e++)
      for (int mi = 0; mi < 3; mi++)
        do_cmp(1'b0, 1'b1, 2'b00, (e == N) ? 8'hEE : m_key[e],
               (mi == 0) ? 8'h00 : (mi == 1) ? 8'hF0 : 8'hFF, "R4 auto");
    // R5: force wins when both strobes are high
    do_cmp(1'b1, 1'b1, 2'b10, m_key[1], 8'hFF, "R5 both");
    do_cmp(1'b1, 1'b1, 2'b11, 8'h00, 8'hFF, "R5 both ram");
    // R6: single-bit masks
    for (int b = 0; b < KW; b++) do_cmp(1'b1, 1'b0, 2'b01, m_key[0] ^ KW'(1 << b),
                                        KW'(1 << b), "R6 bit");

    // R9: results hold while inputs wiggle without a strobe
    do_cmp(1'b1, 1'b0, 2'b01, 8'h00, 8'hFF, "R9 setup");
    mf = match_flag; mu = multi_flag; ma = match_addr;
    @(negedge clk); cmp_key = 8'h55; cmp_mask = 8'h00; cmp_type = 2'b11;
    do_wr(3, 8'h77, 8'h11, 2'b01, 8'h00);
    @(negedge clk);
    chk(match_flag == mf && multi_flag == mu && match_addr == ma, "R9 hold",
        int'({match_flag, multi_flag, match_addr}), int'({mf, mu, ma}));

    // R3: masked write keeps protected bits, data field fully written
    do_wr(2, 8'h00, 8'h5A, 2'b10, 8'hF0);
    do_rd(2);
    do_wr(2, 8'hFF, 8'hC3, 2'b01, 8'h3C);
    do_rd(2);
    do_cmp(1'b0, 1'b1, 2'b00, m_key[2], 8'h00, "R3 masked key found");

    // R11: make full, then open a single slot
    for (int i = 0; i < N; i++) if (m_type[i] == 2'b00) do_wr(i, 8'h99, 8'h00, 2'b11, 8'h00);
    chk_free("R11 full");
    do_wr(6, 8'h00, 8'h00, 2'b00, 8'hFF);
    chk_free("R11 one slot");
    do_wr(1, 8'h00, 8'h00, 2'b00, 8'h00);
    chk_free("R11 lower slot");
    // R2: searching Empty entries finds the freed ones
    do_cmp(1'b1, 1'b0, 2'b00, 8'h00, 8'hFF, "R2 empty search");
    // R10: status holds without read
    do_rd(4);
    @(negedge clk);
    chk(rd_status == m_type[4], "R10 hold", int'(rd_status), int'(m_type[4]));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule